// File: doc/BRIEF.md
# Write-Drain Mode Controller

This block decides, cycle by cycle, whether a data bus that reads and writes share is pointed at reads or at writes. Writes wait in a pending write queue outside the block, and the controller sees only how full that queue is. It keeps the bus on reads until the write queue fills up to an upper threshold. It then turns the bus around and stays on writes until the queue has emptied down to a lower threshold. Because the two thresholds are apart, writes leave in bursts and the cost of turning the bus around is spread over many transfers.

Every change of direction starts a fixed idle window. During that window no command may be issued and the mode cannot change again. When the read queue is empty and writes are waiting, the controller can also start draining early, below the upper threshold, so an idle bus does useful work. The queues themselves and the command logic stay outside; the block only supplies the mode, a busy flag for the turnaround window and an issue-enable.

Top module: `wdrain_mode_ctrl`

## Requirements
- R1: After reset the block is in read mode (`mode_wr` = 0) and `turn_busy` is 0.
- R2: In read mode, with `lo_mark` < `hi_mark` and no turnaround in progress, a write count of `hi_mark` or more switches the mode to write at the next clock edge. A count below `hi_mark` with reads pending does not switch it.
- R3: In write mode, with no turnaround in progress and the read queue not empty, a write count at or below `lo_mark` switches the mode back to read at the next clock edge.
- R4: With reads pending and a write count strictly between `lo_mark` and `hi_mark`, the current mode is held in both directions.
- R5: In read mode with the read queue empty (`rq_empty` = 1) and a nonzero write count, the mode switches to write at the next edge even when the count is below `hi_mark`.
- R6: In write mode with the read queue empty, a nonzero count at or below `lo_mark` keeps write mode. A count of zero returns the bus to read mode.
- R7: Each mode change makes `turn_busy` 1 for exactly TURN_CYC (default 3) cycles, starting with the edge that changes the mode.
- R8: While `turn_busy` is 1, `issue_en` is 0 and the mode does not change, whatever the inputs do.
- R9: Outside a turnaround, `issue_en` equals "read queue not empty" in read mode and "write count nonzero" in write mode.
- R10: When `lo_mark` is not below `hi_mark`, the watermark trigger is disabled. With reads pending, read mode is kept at any write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wq_count | input | CNT_W | Occupancy of the pending write queue |
| rq_empty | input | 1 | 1 when the read queue holds nothing |
| hi_mark | input | CNT_W | Occupancy at which write draining starts |
| lo_mark | input | CNT_W | Occupancy at which draining ends |
| mode_wr | output | 1 | 0 = read mode, 1 = write mode |
| turn_busy | output | 1 | Bus turnaround window in progress |
| issue_en | output | 1 | A command of the current mode may issue |

## Verification
The embedded properties check the rules that hold on every cycle. Nothing issues and the mode stays frozen while the turnaround window runs. A mode change always opens that window. A count at the upper threshold forces write mode when the thresholds are valid, and counts between the thresholds hold the mode. The directed scenarios are what show the exact length of the window, the order of a full fill-and-drain cycle, the early drain on an empty read queue with its exit at zero, and the disabled trigger when the thresholds are inverted.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
    } fsm_state_t;

endpackage

// File: rtl/wdm_trigger.sv
module wdm_trigger #(
    parameter int CNT_W       = 6,
    parameter bit OPPORTUNIST = 1'b1
) (
    input  logic [CNT_W-1:0] wq_count,
    input  logic             rq_empty,
    input  logic [CNT_W-1:0] hi_mark,
    input  logic [CNT_W-1:0] lo_mark,
    output logic             enter_wr,
    output logic             leave_wr
);

    logic cfg_ok;
    logic hit_hi;
    logic idle_fill;
    logic at_low;
    logic q_zero;

    always_comb begin
        cfg_ok    = (lo_mark < hi_mark);
        q_zero    = (wq_count == '0);
        // R10: inverted thresholds disable the watermark trigger
        hit_hi    = cfg_ok && (wq_count >= hi_mark);
        // R5: drain early when reads have nothing to do
        idle_fill = OPPORTUNIST && rq_empty && !q_zero;
        at_low    = (wq_count <= lo_mark);
        enter_wr  = hit_hi || idle_fill;
        // R3 / R6: leave at the low mark unless an idle read side keeps draining
        leave_wr  = q_zero || (at_low && (!rq_empty || !OPPORTUNIST));
    end

endmodule

// File: rtl/wdm_turn_timer.sv
module wdm_turn_timer #(
    parameter int TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int TURN_W = (TURN_CYC < 1) ? 1 : $clog2(TURN_CYC + 1);

    generate
        if (TURN_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_cnt
            typedef struct packed {
                logic [TURN_W-1:0] left;
            } tmr_state_t;

            tmr_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (start) begin
                    st_d.left = TURN_W'(TURN_CYC);
                end else if (st_q.left != '0) begin
                    st_d.left = st_q.left - 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign busy = (st_q.left != '0);

            // R7
            start_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> busy);
            // R8
            no_restart_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                busy |-> !start);
        end
    endgenerate

endmodule

// File: rtl/wdm_mode_fsm.sv
module wdm_mode_fsm
    import wdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_wr,
    input  logic      leave_wr,
    input  logic      busy,
    output bus_mode_e mode,
    output logic      flip
);

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        flip = 1'b0;
        if (!busy) begin
            unique case (st_q.mode)
                MODE_RD: flip = enter_wr;
                MODE_WR: flip = leave_wr;
                default: flip = 1'b0;
            endcase
        end
        if (flip) begin
            st_d.mode = (st_q.mode == MODE_RD) ? MODE_WR : MODE_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R8
    frozen_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.mode));

endmodule

// File: rtl/wdrain_mode_ctrl.sv
module wdrain_mode_ctrl
    import wdm_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int TURN_CYC    = 3,
    parameter bit OPPORTUNIST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wq_count,
    input  logic             rq_empty,
    input  logic [CNT_W-1:0] hi_mark,
    input  logic [CNT_W-1:0] lo_mark,
    output logic             mode_wr,
    output logic             turn_busy,
    output logic             issue_en
);

    logic      enter_wr;
    logic      leave_wr;
    logic      flip;
    logic      busy;
    bus_mode_e mode;

    wdm_trigger #(
        .CNT_W      (CNT_W),
        .OPPORTUNIST(OPPORTUNIST)
    ) u_trigger (
        .wq_count(wq_count),
        .rq_empty(rq_empty),
        .hi_mark (hi_mark),
        .lo_mark (lo_mark),
        .enter_wr(enter_wr),
        .leave_wr(leave_wr)
    );

    wdm_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter_wr(enter_wr),
        .leave_wr(leave_wr),
        .busy    (busy),
        .mode    (mode),
        .flip    (flip)
    );

    wdm_turn_timer #(
        .TURN_CYC(TURN_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(flip),
        .busy (busy)
    );

    always_comb begin
        mode_wr   = (mode == MODE_WR);
        turn_busy = busy;
        // R9
        if (busy) begin
            issue_en = 1'b0;
        end else if (mode == MODE_WR) begin
            issue_en = (wq_count != '0);
        end else begin
            issue_en = !rq_empty;
        end
    end

    // R8
    no_issue_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_busy |-> !issue_en);

    // R2
    high_mark_forces_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!turn_busy && !mode_wr && (lo_mark < hi_mark) && (wq_count >= hi_mark)) |=> mode_wr);

    // R4
    hysteresis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!turn_busy && !rq_empty && (wq_count > lo_mark) && (wq_count < hi_mark))
            |=> $stable(mode_wr));

    generate
        if (TURN_CYC > 0) begin : g_turn_chk
            // R7
            change_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(mode_wr) |-> turn_busy);
        end
    endgenerate

endmodule

// File: tb/wdrain_mode_ctrl_tb.sv
module wdrain_mode_ctrl_tb;

    localparam int CNT_W    = 6;
    localparam int TURN_CYC = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] wq_count;
    logic             rq_empty;
    logic [CNT_W-1:0] hi_mark;
    logic [CNT_W-1:0] lo_mark;
    logic             mode_wr;
    logic             turn_busy;
    logic             issue_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdrain_mode_ctrl #(
        .CNT_W   (CNT_W),
        .TURN_CYC(TURN_CYC)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wq_count (wq_count),
        .rq_empty (rq_empty),
        .hi_mark  (hi_mark),
        .lo_mark  (lo_mark),
        .mode_wr  (mode_wr),
        .turn_busy(turn_busy),
        .issue_en (issue_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic to_read_idle();
        wq_count = '0;
        rq_empty = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (!mode_wr && !turn_busy) break;
            tick();
        end
    endtask

    task automatic expect_window(string req);
        chk(req, turn_busy, 1);
        for (int i = 1; i < TURN_CYC; i++) begin
            tick();
            chk(req, turn_busy, 1);
        end
        tick();
        chk(req, turn_busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_wr, 0);
        chk("R1 busy", turn_busy, 0);
        chk("R9 read issue", issue_en, 1);
        rq_empty = 1'b1;
        wq_count = '0;
        #0;
        chk("R9 read idle", issue_en, 0);
        rq_empty = 1'b0;
    endtask

    task automatic t_fill_drain();
        to_read_idle();
        wq_count = 6'd11;
        tick();
        chk("R2 below high", mode_wr, 0);
        wq_count = 6'd12;
        tick();
        chk("R2 at high", mode_wr, 1);
        chk("R8 no issue", issue_en, 0);
        expect_window("R7 enter window");
        chk("R9 write issue", issue_en, 1);
        wq_count = 6'd8;
        tick();
        chk("R4 hold write", mode_wr, 1);
        wq_count = 6'd5;
        tick();
        chk("R4 hold write 5", mode_wr, 1);
        wq_count = 6'd4;
        tick();
        chk("R3 at low", mode_wr, 0);
        expect_window("R7 leave window");
        wq_count = 6'd8;
        tick();
        chk("R4 hold read", mode_wr, 0);
        tick();
        chk("R4 hold read 2", mode_wr, 0);
    endtask

    task automatic t_frozen();
        to_read_idle();
        wq_count = 6'd20;
        tick();
        chk("R2 above high", mode_wr, 1);
        wq_count = '0;
        for (int i = 0; i < TURN_CYC - 1; i++) begin
            tick();
            chk("R8 frozen mode", mode_wr, 1);
            chk("R8 frozen issue", issue_en, 0);
        end
        tick();
        chk("R8 busy ends", turn_busy, 0);
        chk("R8 mode after window", mode_wr, 1);
        tick();
        chk("R3 leaves after window", mode_wr, 0);
    endtask

    task automatic t_idle_drain();
        to_read_idle();
        wq_count = 6'd3;
        rq_empty = 1'b1;
        tick();
        chk("R5 early drain", mode_wr, 1);
        for (int i = 0; i < TURN_CYC; i++) tick();
        chk("R6 window done", turn_busy, 0);
        tick();
        chk("R6 stays below low", mode_wr, 1);
        chk("R9 write issue low", issue_en, 1);
        wq_count = '0;
        #0;
        chk("R9 write empty", issue_en, 0);
        tick();
        chk("R6 empty exits", mode_wr, 0);
        for (int i = 0; i < TURN_CYC; i++) tick();
        tick();
        chk("R6 no re-entry on empty", mode_wr, 0);
    endtask

    task automatic t_bad_marks();
        to_read_idle();
        hi_mark  = 6'd4;
        lo_mark  = 6'd6;
        wq_count = 6'd20;
        tick();
        tick();
        tick();
        chk("R10 no trigger", mode_wr, 0);
        chk("R10 no busy", turn_busy, 0);
        hi_mark = 6'd12;
        lo_mark = 6'd4;
        tick();
        chk("R2 valid again", mode_wr, 1);
        to_read_idle();
    endtask

    initial begin
        rst_n    = 1'b0;
        wq_count = '0;
        rq_empty = 1'b0;
        hi_mark  = 6'd12;
        lo_mark  = 6'd4;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fill_drain();
        t_frozen();
        t_idle_drain();
        t_bad_marks();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule